// File: doc/BRIEF.md
# Strobe-Clocked DDR Read Capture Buffer

This block takes read data from a double-data-rate memory interface and hands it to the controller's system clock domain, which runs 90 degrees behind the main clock. Each data byte comes with its own delayed data strobe. The strobe acts as the write clock, and no other register or divided clock sits between the data pins and the storage. The block keeps two small FIFOs, both 16 bits wide. One holds the beats sampled on the strobe's rising edge and the other holds the beats sampled on its falling edge. Bits 7:0 are written under strobe 0 and bits 15:8 under strobe 1.

A read-window input marks the beats of a burst. It is sampled on every strobe edge as the write enable. Each FIFO passes a Gray-coded write pointer, taken from the strobe-0 lane, through two flip-flops in the 90-degree domain. There it is compared with a Gray-coded read pointer to form the empty flag.

A small read controller has two states:

- `CAP_WAIT`: one or both FIFOs are empty.
- `CAP_SEND`: an entry was popped from each FIFO on the previous edge.

The controller moves `CAP_WAIT -> CAP_SEND` or stays in `CAP_SEND` when both FIFOs are non-empty. It moves `CAP_SEND -> CAP_WAIT` or stays in `CAP_WAIT` otherwise. In `CAP_SEND` the valid output is high and the rising and falling words are presented together.

Top module: `ddr_rdcap_top`

## Requirements
- R1: While `rst` is high, and on the first 90-degree clock edge after it is released, `rd_valid_o` is low.
- R2: In a valid cycle, `rd_rise_o` holds the data present at a strobe rising edge, and `rd_fall_o` holds the data present at the falling edge that follows it.
- R3: Strobe edges at which `rd_window` is low write nothing, so no output word results from them.
- R4: `rd_valid_o` is asserted only when both FIFOs held an entry on the previous edge. A beat written only on a rising edge, with no falling beat after it, never produces an output.
- R5: `rst` clears both read pointers, both write pointers and the valid output. Entries buffered before the reset never appear afterwards, and both FIFOs read as empty right after it.
- R6: Bits 7:0 of both words are sampled by `dqs_dly[0]`, and bits 15:8 are sampled by `dqs_dly[1]`.
- R7: Words leave in the order their beats were written, with no loss and no duplication. Each valid cycle pops exactly one entry from each FIFO, so the two read pointers stay equal.
- R8: The read pointers are Gray-coded, and only one bit changes when they advance. A pair of beats is delivered within five 90-degree clock cycles of its falling-edge write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk90 | input | 1 | System clock, 90 degrees behind the main clock; read side |
| rst | input | 1 | Active-high reset. Synchronous on the read side, asynchronous on the strobe-clocked write side |
| dqs_dly | input | 2 | Delayed data strobes; bit 0 clocks data bits 7:0, bit 1 clocks bits 15:8 |
| dq_in | input | 16 | Read data from the memory pins |
| rd_window | input | 1 | High across the beats of a read burst; write enable sampled on each strobe edge |
| rd_valid_o | output | 1 | One-cycle pulse per delivered rising/falling word pair |
| rd_rise_o | output | 16 | Word captured on a strobe rising edge |
| rd_fall_o | output | 16 | Word captured on the following strobe falling edge |

## Verification
The bench drives four-beat strobe bursts at several phase offsets from the 90-degree clock. Every word must come out in order. A design that swapped the edges or paired entries badly would show up as a rise/fall mismatch, and a lost or repeated pop as a missing or surplus word.

One burst changes the upper byte between the two strobes' edges. If the upper byte were sampled by the wrong strobe, the bench would see the stale value.

Strobe edges with the window low must write nothing, or extra words appear. A lone rising-edge write must produce nothing, or a valid fires with only one FIFO filled. A reset must then flush that orphan entry; if it did not, every later pair would be misaligned by one.

// File: rtl/ddr_rdcap_pkg.sv
package ddr_rdcap_pkg;

    // Read-side controller states
    typedef enum logic [0:0] {
        CAP_WAIT = 1'b0,   // at least one FIFO empty, nothing delivered
        CAP_SEND = 1'b1    // one entry popped from each FIFO on the last edge
    } cap_state_e;

endpackage

// File: rtl/ddr_rdcap_gray_fifo.sv
// Strobe-written FIFO. Each byte lane is written by its own strobe edge;
// the lane-0 pointer is Gray-coded and crossed into the read clock.
module ddr_rdcap_gray_fifo #(
    parameter int DW        = 16,
    parameter int LANES     = 2,
    parameter int DEPTH     = 8,
    parameter bit FALL_EDGE = 1'b0
) (
    input  logic                 rst,
    input  logic [LANES-1:0]     stb,
    input  logic                 win,
    input  logic [DW-1:0]        din,
    input  logic                 clk_rd,
    input  logic                 pop,
    output logic [DW-1:0]        dout,
    output logic                 empty,
    output logic [$clog2(DEPTH):0] rd_gray_o
);
    localparam int LW = DW / LANES;
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic [PW-1:0] wr_gray;     // lane-0 strobe domain
    logic [PW-1:0] wsync_a;     // first read-domain stage
    logic [PW-1:0] wsync_b;     // second read-domain stage
    logic [PW-1:0] rd_bin;
    logic [PW-1:0] rd_gray;
    logic [PW-1:0] rd_bin_nxt;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic          wclk;
        logic [AW-1:0] waddr;
        logic [LW-1:0] mem [DEPTH];

        // Pick the capturing edge of this lane's strobe.
        if (FALL_EDGE) begin : g_fall
            assign wclk = ~stb[l];
        end else begin : g_rise
            assign wclk = stb[l];
        end

        if (l == 0) begin : g_ptr
            // Lane 0 owns the wrap bit and the Gray pointer that crosses.
            logic [PW-1:0] wbin;
            logic [PW-1:0] wbin_nxt;
            assign wbin_nxt = wbin + PW'(1);
            assign waddr    = wbin[AW-1:0];
            always_ff @(posedge wclk or posedge rst) begin
                if (rst) begin
                    wbin    <= '0;
                    wr_gray <= '0;
                end else if (win) begin
                    wbin    <= wbin_nxt;
                    wr_gray <= wbin_nxt ^ (wbin_nxt >> 1);
                end
            end
        end else begin : g_addr
            logic [AW-1:0] wcnt;
            assign waddr = wcnt;
            always_ff @(posedge wclk or posedge rst) begin
                if (rst) begin
                    wcnt <= '0;
                end else if (win) begin
                    wcnt <= wcnt + AW'(1);
                end
            end
        end

        always_ff @(posedge wclk) begin
            if (win) begin
                mem[waddr] <= din[l*LW +: LW];
            end
        end

        assign dout[l*LW +: LW] = mem[rd_bin[AW-1:0]];
    end

    // Two-flop crossing of the write pointer into the read clock.
    always_ff @(posedge clk_rd) begin
        if (rst) begin
            wsync_a <= '0;
            wsync_b <= '0;
        end else begin
            wsync_a <= wr_gray;
            wsync_b <= wsync_a;
        end
    end

    assign rd_bin_nxt = rd_bin + PW'(1);

    always_ff @(posedge clk_rd) begin
        if (rst) begin
            rd_bin  <= '0;
            rd_gray <= '0;
        end else if (pop) begin
            rd_bin  <= rd_bin_nxt;
            rd_gray <= rd_bin_nxt ^ (rd_bin_nxt >> 1);
        end
    end

    assign empty     = (wsync_b == rd_gray);
    assign rd_gray_o = rd_gray;

endmodule

// File: rtl/ddr_rdcap_rd_ctrl.sv
// Read-side controller: pops both FIFOs together and registers the pair.
module ddr_rdcap_rd_ctrl
    import ddr_rdcap_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk90,
    input  logic          rst,
    input  logic          rise_empty,
    input  logic          fall_empty,
    input  logic [DW-1:0] rise_data,
    input  logic [DW-1:0] fall_data,
    output logic          pop,
    output logic          valid_o,
    output logic [DW-1:0] rise_o,
    output logic [DW-1:0] fall_o
);
    cap_state_e state_q;
    cap_state_e state_d;
    logic       both_ready;

    assign both_ready = !rise_empty && !fall_empty;
    assign pop        = both_ready;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CAP_WAIT: state_d = both_ready ? CAP_SEND : CAP_WAIT;
            CAP_SEND: state_d = both_ready ? CAP_SEND : CAP_WAIT;
            default:  state_d = CAP_WAIT;
        endcase
    end

    // State register
    always_ff @(posedge clk90) begin
        if (rst) begin
            state_q <= CAP_WAIT;
        end else begin
            state_q <= state_d;
        end
    end

    // Output registers
    always_ff @(posedge clk90) begin
        if (rst) begin
            rise_o <= '0;
            fall_o <= '0;
        end else begin
            unique case (state_d)
                CAP_SEND: begin
                    rise_o <= rise_data;
                    fall_o <= fall_data;
                end
                CAP_WAIT: begin
                    rise_o <= rise_o;
                    fall_o <= fall_o;
                end
                default: begin
                    rise_o <= rise_o;
                    fall_o <= fall_o;
                end
            endcase
        end
    end

    assign valid_o = (state_q == CAP_SEND);

endmodule

// File: rtl/ddr_rdcap_top.sv
// DDR read capture: rising and falling beat FIFOs with Gray crossing.
module ddr_rdcap_top #(
    parameter int DW    = 16,
    parameter int LANES = 2,
    parameter int DEPTH = 8
) (
    input  logic             clk90,
    input  logic             rst,
    input  logic [LANES-1:0] dqs_dly,
    input  logic [DW-1:0]    dq_in,
    input  logic             rd_window,
    output logic             rd_valid_o,
    output logic [DW-1:0]    rd_rise_o,
    output logic [DW-1:0]    rd_fall_o
);
    localparam int PW = $clog2(DEPTH) + 1;

    logic          pop;
    logic          rise_empty;
    logic          fall_empty;
    logic [DW-1:0] rise_data;
    logic [DW-1:0] fall_data;
    logic [PW-1:0] rise_rd_gray;
    logic [PW-1:0] fall_rd_gray;

    ddr_rdcap_gray_fifo #(
        .DW(DW), .LANES(LANES), .DEPTH(DEPTH), .FALL_EDGE(1'b0)
    ) u_rise_fifo (
        .rst       (rst),
        .stb       (dqs_dly),
        .win       (rd_window),
        .din       (dq_in),
        .clk_rd    (clk90),
        .pop       (pop),
        .dout      (rise_data),
        .empty     (rise_empty),
        .rd_gray_o (rise_rd_gray)
    );

    ddr_rdcap_gray_fifo #(
        .DW(DW), .LANES(LANES), .DEPTH(DEPTH), .FALL_EDGE(1'b1)
    ) u_fall_fifo (
        .rst       (rst),
        .stb       (dqs_dly),
        .win       (rd_window),
        .din       (dq_in),
        .clk_rd    (clk90),
        .pop       (pop),
        .dout      (fall_data),
        .empty     (fall_empty),
        .rd_gray_o (fall_rd_gray)
    );

    ddr_rdcap_rd_ctrl #(
        .DW(DW)
    ) u_rd_ctrl (
        .clk90      (clk90),
        .rst        (rst),
        .rise_empty (rise_empty),
        .fall_empty (fall_empty),
        .rise_data  (rise_data),
        .fall_data  (fall_data),
        .pop        (pop),
        .valid_o    (rd_valid_o),
        .rise_o     (rd_rise_o),
        .fall_o     (rd_fall_o)
    );

endmodule

// File: rtl/ddr_rdcap_chk.sv
module ddr_rdcap_chk #(
    parameter int PW = 4
) (
    input logic          clk90,
    input logic          rst,
    input logic          rd_valid_o,
    input logic          rise_empty,
    input logic          fall_empty,
    input logic [PW-1:0] rise_rd_gray,
    input logic [PW-1:0] fall_rd_gray
);
    logic rst_q;

    always_ff @(posedge clk90) begin
        rst_q <= rst;
    end

    always_ff @(posedge clk90) begin
        if (rst_q === 1'b1) begin
            AST_RESET_QUIET: assert (!rd_valid_o);                     // R1
            AST_EMPTY_AFTER_RESET: assert (rise_empty && fall_empty);  // R5
        end
    end

    AST_POP_NEEDS_DATA: assert property (@(posedge clk90) disable iff (rst)
        !$stable(rise_rd_gray) |-> $past(!rise_empty && !fall_empty)); // R4

    AST_RD_PTRS_ALIGNED: assert property (@(posedge clk90) disable iff (rst)
        rise_rd_gray == fall_rd_gray);                                 // R7

    AST_VALID_MEANS_POP: assert property (@(posedge clk90) disable iff (rst)
        rd_valid_o |-> !$stable(rise_rd_gray));                        // R7

    AST_GRAY_ONE_BIT: assert property (@(posedge clk90) disable iff (rst)
        !$stable(rise_rd_gray) |->
            $countones(rise_rd_gray ^ $past(rise_rd_gray)) == 1);      // R8

endmodule

bind ddr_rdcap_top ddr_rdcap_chk #(.PW(PW)) u_chk (
    .clk90        (clk90),
    .rst          (rst),
    .rd_valid_o   (rd_valid_o),
    .rise_empty   (rise_empty),
    .fall_empty   (fall_empty),
    .rise_rd_gray (rise_rd_gray),
    .fall_rd_gray (fall_rd_gray)
);

// File: tb/ddr_rdcap_top_tb_top.sv
`timescale 1ns/100ps
module ddr_rdcap_top_tb_top;
    logic        clk90 = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  dqs = 2'b00;
    logic [15:0] dq = '0;
    logic        win = 1'b0;
    logic        rd_valid_o;
    logic [15:0] rd_rise_o;
    logic [15:0] rd_fall_o;

    int n_chk = 0;
    int n_fail = 0;
    int n_push = 0;
    int n_pop = 0;
    bit done = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #5 clk90 = ~clk90;

    ddr_rdcap_top dut_i (
        .clk90      (clk90),
        .rst        (rst),
        .dqs_dly    (dqs),
        .dq_in      (dq),
        .rd_window  (win),
        .rd_valid_o (rd_valid_o),
        .rd_rise_o  (rd_rise_o),
        .rd_fall_o  (rd_fall_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One strobe period: rising beat R, falling beat F. With skew set, the
    // upper byte changes between strobe 0 and strobe 1 edges (R6).
    task automatic beat_pair(input logic [15:0] r, input logic [15:0] f,
                             input bit wen, input bit skew);
        logic [15:0] er;
        logic [15:0] ef;
        er = skew ? {~r[15:8], r[7:0]} : r;
        ef = skew ? {~f[15:8], f[7:0]} : f;
        win = wen;
        dq  = r;
        #1.0 dqs[0] = 1'b1;
        #0.2 if (skew) dq[15:8] = ~r[15:8];
        #0.3 dqs[1] = 1'b1;
        #1.5 dq = f;
        #3.0 dqs[0] = 1'b0;
        #0.2 if (skew) dq[15:8] = ~f[15:8];
        #0.3 dqs[1] = 1'b0;
        if (wen) begin
            exp_q.push_back({er, ef});
            tag_q.push_back(skew ? "R6" : "R2");
            n_push++;
        end
        #3.5;
    endtask

    task automatic burst(input logic [15:0] seed, input bit wen, input bit skew);
        for (int i = 0; i < 2; i++) begin
            beat_pair(seed + 16'(i * 16'h1111), ~(seed + 16'(i * 16'h0203)), wen, skew);
        end
        win = 1'b0;
    endtask

    // Monitor: pops expected pairs as the design delivers them.
    always @(negedge clk90) begin
        if (rst) begin
            if (rd_valid_o) check(1'b0, "R1", "valid during reset", 32'd1, 32'd0);
        end else if (rd_valid_o) begin
            n_pop++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R7", "unexpected word", {rd_rise_o, rd_fall_o}, 32'd0);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(rd_rise_o == e[31:16], t, "rise word", {16'd0, rd_rise_o}, {16'd0, e[31:16]});
                check(rd_fall_o == e[15:0],  t, "fall word", {16'd0, rd_fall_o}, {16'd0, e[15:0]});
            end
        end
    end

    task automatic finish_run;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk90);
        if (!done) begin
            check(1'b0, "WD", "watchdog expired", 32'd0, 32'd1);
            finish_run();
        end
    end

    initial begin
        int pops_before;
        repeat (4) @(posedge clk90);
        @(negedge clk90);
        check(rd_valid_o == 1'b0, "R1", "valid in reset", {31'd0, rd_valid_o}, 32'd0);
        rst = 1'b0;
        @(negedge clk90);
        check(rd_valid_o == 1'b0, "R1", "valid after release", {31'd0, rd_valid_o}, 32'd0);
        repeat (3) @(posedge clk90);

        // R2: basic four-beat burst
        @(posedge clk90); #2.3;
        burst(16'h1234, 1'b1, 1'b0);
        repeat (5) @(posedge clk90);
        @(negedge clk90);
        check(exp_q.size() == 0, "R8", "latency after burst", 32'(exp_q.size()), 32'd0);

        // R7: back-to-back bursts at several phases and patterns
        @(posedge clk90); #1.1; burst(16'h0001, 1'b1, 1'b0);
        @(posedge clk90); #4.7; burst(16'hFFFF, 1'b1, 1'b0);
        burst(16'hA5A5, 1'b1, 1'b0);
        @(posedge clk90); #7.9; burst(16'h8000, 1'b1, 1'b0);
        burst(16'h0000, 1'b1, 1'b0);
        repeat (6) @(posedge clk90);
        @(negedge clk90);
        check(exp_q.size() == 0, "R7", "queue drained", 32'(exp_q.size()), 32'd0);

        // R6: upper byte changes between the two strobes' edges
        @(posedge clk90); #3.3;
        burst(16'h3C5A, 1'b1, 1'b1);
        repeat (6) @(posedge clk90);

        // R3: strobe edges with the window low
        pops_before = n_pop;
        @(posedge clk90); #2.0;
        burst(16'h7777, 1'b0, 1'b0);
        repeat (8) @(posedge clk90);
        @(negedge clk90);
        check(n_pop == pops_before, "R3", "words from closed window", 32'(n_pop - pops_before), 32'd0);

        // R4: rising-edge-only write
        pops_before = n_pop;
        @(posedge clk90); #2.0;
        win = 1'b1; dq = 16'hDEAD;
        #1.0 dqs = 2'b11;
        #2.0 win = 1'b0;
        #3.0 dqs = 2'b00;
        repeat (10) @(posedge clk90);
        @(negedge clk90);
        check(n_pop == pops_before, "R4", "valid with falling FIFO empty", 32'(n_pop - pops_before), 32'd0);

        // R5: reset flushes the orphan rising entry
        rst = 1'b1;
        repeat (3) @(posedge clk90);
        @(negedge clk90);
        check(rd_valid_o == 1'b0, "R5", "valid in reset", {31'd0, rd_valid_o}, 32'd0);
        rst = 1'b0;
        repeat (2) @(posedge clk90);
        @(posedge clk90); #5.5;
        burst(16'h4B1D, 1'b1, 1'b0);
        burst(16'h0F0F, 1'b1, 1'b0);
        repeat (8) @(posedge clk90);
        @(negedge clk90);
        check(exp_q.size() == 0, "R5", "post-reset words delivered", 32'(exp_q.size()), 32'd0);
        check(n_pop == n_push, "R7", "pop count equals push count", 32'(n_pop), 32'(n_push));

        done = 1'b1;
        finish_run();
    end

endmodule